// File: doc/BRIEF.md
# DS3 C-bit Serial Extraction Port

This block sits behind a DS3 receive framer running in C-bit parity mode. The framer marks each received C-bit with its subframe number and its position within the subframe. The block keeps fourteen of the twenty-one C-bits of every M-frame: C2 to C6 and C13 to C21. When the framer signals the end of the M-frame, the block moves those bits into a shift register. It then sends them out serially in ascending C-bit order during the following frame.

The serial side has four lines. A data line carries the bits. A bit-clock enable pulses for one DS3 clock per output bit, with `BIT_DIV` DS3 clocks between pulses. A frame pulse marks the first bit of each sequence. A data-link strobe marks the three data-link C-bits (C13, C14, C15).

There is no back-pressure on either side. The framer cannot be stalled, so every qualified C-bit is taken in the cycle it is offered. The serial consumer must accept each bit in the cycle its enable pulses. The out-of-frame input silences the port completely and discards any frame it touches.

Top module: `cbit_serial_port`

## Requirements
- R1: After reset, `ser_clk_en`, `ser_data`, `ser_frame` and `ser_dl` are all low.
- R2: Each exported frame gives exactly 14 `ser_clk_en` pulses. On pulse k (k = 0..13), `ser_data` carries C-bit number k+2 for k < 5 and k+8 otherwise. That C-bit value is the one captured in the preceding M-frame. `ser_data` is low whenever `ser_clk_en` is low. `cbit_valid` and `mframe_end` are never high in the same cycle.
- R3: C-bit numbering is (`cbit_sub`-1)*3 + `cbit_idx`, with `cbit_sub` in 1..7 and `cbit_idx` in 1..3. Bits C1 and C7 to C12 do not affect the output.
- R4: `ser_frame` is high only together with pulse k = 0 (C2).
- R5: `ser_dl` is high exactly together with pulses k = 5, 6 and 7 (C13, C14, C15).
- R6: Pulse 0 appears one clock after the cycle in which `mframe_end` is high. Each later pulse follows the previous one after exactly `BIT_DIV` clocks (`BIT_DIV` >= 2).
- R7: Capture storage is cleared at every M-frame end. A selected C-bit that is not offered during a frame is exported as 0.
- R8: One clock after `in_oof` is high, all four serial outputs are low, and a transmission in progress is abandoned. A frame is exported only if the previous `mframe_end` was seen and `in_oof` has been low from then on, up to and including its own `mframe_end`.
- R9: An `mframe_end` that arrives during a transmission abandons it and restarts with the new frame, following the timing of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DS3 receive bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_oof | input | 1 | Framer out-of-frame indication |
| cbit_valid | input | 1 | Current received bit is a C-bit |
| cbit_sub | input | 3 | Subframe number of the C-bit, 1..7 |
| cbit_idx | input | 2 | C-bit position within the subframe, 1..3 |
| rx_bit | input | 1 | Received bit value |
| mframe_end | input | 1 | One-cycle pulse at the end of each M-frame |
| ser_data | output | 1 | Serial C-bit data |
| ser_clk_en | output | 1 | One-cycle bit-clock enable per output bit |
| ser_frame | output | 1 | Marks the first bit (C2) of a sequence |
| ser_dl | output | 1 | Marks the data-link bits C13, C14, C15 |

## Verification
The first kind of internal fault is a wrong slot counter or capture index. It shows up within one frame as a bit in the wrong position, or as frame or data-link strobes on the wrong pulse. A pacing-counter fault changes the spacing between enable pulses from the second bit on. The second kind is a stale validity flag. It shows up one frame late: a frame that straddled an out-of-frame interval, or the first frame after reset, is transmitted when it should be dropped. Random frames cover the bit mapping, and directed cases cover out-of-frame recovery and a restart in mid-transmission.

// File: rtl/cbit_port_pkg.sv
package cbit_port_pkg;
  localparam int unsigned SUB_W    = 3;
  localparam int unsigned IDX_W    = 2;
  localparam int unsigned PER_SUB  = 3;
  localparam int unsigned NUM_EXP  = 14;
  localparam int unsigned SLOT_W   = $clog2(NUM_EXP);
  localparam int unsigned NUM_W    = 5;
  // exported C-bit groups: first group low range, second group high range
  localparam int unsigned LO_FIRST = 2;
  localparam int unsigned LO_LAST  = 6;
  localparam int unsigned HI_FIRST = 13;
  localparam int unsigned HI_LAST  = 21;
  localparam int unsigned HI_BASE  = HI_FIRST - (LO_LAST - LO_FIRST + 1);
  localparam int unsigned DL_FIRST = 5;
  localparam int unsigned DL_LAST  = 7;
  localparam int unsigned LAST_SLOT = NUM_EXP - 1;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_map_t;

  // Map a (subframe, index) marker to an export slot.
  function automatic slot_map_t map_cbit(input logic [SUB_W-1:0] sub,
                                         input logic [IDX_W-1:0] idx);
    slot_map_t  m;
    logic [NUM_W-1:0] n;
    m = '0;
    n = {2'b00, sub - 3'd1} * NUM_W'(PER_SUB) + {3'b000, idx};
    if (sub >= 3'd1 && sub <= 3'd7 && idx >= 2'd1 && idx <= 2'd3) begin
      if (n >= NUM_W'(LO_FIRST) && n <= NUM_W'(LO_LAST)) begin
        m.hit  = 1'b1;
        m.slot = SLOT_W'(n - NUM_W'(LO_FIRST));
      end else if (n >= NUM_W'(HI_FIRST) && n <= NUM_W'(HI_LAST)) begin
        m.hit  = 1'b1;
        m.slot = SLOT_W'(n - NUM_W'(HI_BASE));
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/cbit_capture.sv
module cbit_capture
  import cbit_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_oof,
  input  logic               cbit_valid,
  input  logic [SUB_W-1:0]   cbit_sub,
  input  logic [IDX_W-1:0]   cbit_idx,
  input  logic               rx_bit,
  input  logic               mframe_end,
  output logic               load,
  output logic [NUM_EXP-1:0] frame_bits
);
  slot_map_t          pos;
  logic [NUM_EXP-1:0] cap;
  logic               good;

  assign pos = map_cbit(cbit_sub, cbit_idx);

  for (genvar k = 0; k < NUM_EXP; k++) begin : g_slot
    logic wr;
    assign wr = cbit_valid && pos.hit && (pos.slot == SLOT_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)                   cap[k] <= 1'b0;
      else if (in_oof || mframe_end) cap[k] <= 1'b0;
      else if (wr)                  cap[k] <= rx_bit;
    end
  end

  // good: a frame boundary was seen and no out-of-frame since
  always_ff @(posedge clk) begin
    if (!rst_n)          good <= 1'b0;
    else if (in_oof)     good <= 1'b0;
    else if (mframe_end) good <= 1'b1;
  end

  assign load       = mframe_end && good && !in_oof;
  assign frame_bits = cap;

  p_in_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cbit_valid && mframe_end));
  p_no_load_oof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_oof |=> !load);
endmodule

// File: rtl/cbit_pacer.sv
module cbit_pacer #(
  parameter int unsigned BIT_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;

  if (BIT_DIV < 2) begin : g_bad_div
    $error("BIT_DIV must be at least 2");
  end

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= CNT_W'(BIT_DIV - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign tick = run && (cnt == '0);

  p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/cbit_shifter.sv
module cbit_shifter
  import cbit_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_oof,
  input  logic               load,
  input  logic [NUM_EXP-1:0] frame_bits,
  input  logic               pace_tick,
  output logic               busy,
  output logic               emit,
  output logic               ser_data,
  output logic               ser_clk_en,
  output logic               ser_frame,
  output logic               ser_dl
);
  logic [NUM_EXP-1:0] sh, word;
  logic [SLOT_W-1:0]  slot, slot_cur;

  assign emit     = !in_oof && (load || (busy && pace_tick));
  assign word     = load ? frame_bits : sh;
  assign slot_cur = load ? '0 : slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; slot <= '0; busy <= 1'b0;
      ser_data <= 1'b0; ser_clk_en <= 1'b0; ser_frame <= 1'b0; ser_dl <= 1'b0;
    end else if (in_oof) begin
      busy <= 1'b0;
      ser_data <= 1'b0; ser_clk_en <= 1'b0; ser_frame <= 1'b0; ser_dl <= 1'b0;
    end else if (emit) begin
      ser_clk_en <= 1'b1;
      ser_data   <= word[0];
      ser_frame  <= (slot_cur == '0);
      ser_dl     <= (slot_cur >= SLOT_W'(DL_FIRST)) && (slot_cur <= SLOT_W'(DL_LAST));
      sh         <= word >> 1;
      slot       <= slot_cur + 1'b1;
      busy       <= (slot_cur != SLOT_W'(LAST_SLOT));
    end else begin
      ser_data <= 1'b0; ser_clk_en <= 1'b0; ser_frame <= 1'b0; ser_dl <= 1'b0;
    end
  end

  p_oof_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_oof |=> !(ser_clk_en || ser_data || ser_frame || ser_dl));
  p_frame_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_frame |-> (ser_clk_en && !ser_dl));
  p_dl_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_dl |-> ser_clk_en);
  p_data_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_data |-> ser_clk_en);
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load && !in_oof |=> ser_frame);
  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot <= SLOT_W'(LAST_SLOT)));
endmodule

// File: rtl/cbit_serial_port.sv
module cbit_serial_port
  import cbit_port_pkg::*;
#(
  parameter int unsigned BIT_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_oof,
  input  logic       cbit_valid,
  input  logic [2:0] cbit_sub,
  input  logic [1:0] cbit_idx,
  input  logic       rx_bit,
  input  logic       mframe_end,
  output logic       ser_data,
  output logic       ser_clk_en,
  output logic       ser_frame,
  output logic       ser_dl
);
  logic               load, busy, emit, pace_tick;
  logic [NUM_EXP-1:0] frame_bits;

  cbit_capture u_capture (
    .clk(clk), .rst_n(rst_n), .in_oof(in_oof), .cbit_valid(cbit_valid),
    .cbit_sub(cbit_sub), .cbit_idx(cbit_idx), .rx_bit(rx_bit),
    .mframe_end(mframe_end), .load(load), .frame_bits(frame_bits)
  );

  cbit_pacer #(.BIT_DIV(BIT_DIV)) u_pacer (
    .clk(clk), .rst_n(rst_n), .restart(emit), .run(busy), .tick(pace_tick)
  );

  cbit_shifter u_shifter (
    .clk(clk), .rst_n(rst_n), .in_oof(in_oof), .load(load),
    .frame_bits(frame_bits), .pace_tick(pace_tick), .busy(busy), .emit(emit),
    .ser_data(ser_data), .ser_clk_en(ser_clk_en), .ser_frame(ser_frame),
    .ser_dl(ser_dl)
  );
endmodule

// File: tb/test_cbit_serial_port.sv
module test_cbit_serial_port;
  localparam int DIV = 4;
  localparam logic [20:0] EXP_MASK = 21'h1FF03E; // C2..C6, C13..C21 (bit n-1)

  logic clk = 1'b0, rst_n = 1'b0, in_oof = 1'b0, cbit_valid = 1'b0;
  logic rx_bit = 1'b0, mframe_end = 1'b0;
  logic [2:0] cbit_sub = 3'd0;
  logic [1:0] cbit_idx = 2'd0;
  logic ser_data, ser_clk_en, ser_frame, ser_dl;

  cbit_serial_port #(.BIT_DIV(DIV)) i_cbit_serial_port (
    .clk(clk), .rst_n(rst_n), .in_oof(in_oof), .cbit_valid(cbit_valid),
    .cbit_sub(cbit_sub), .cbit_idx(cbit_idx), .rx_bit(rx_bit),
    .mframe_end(mframe_end), .ser_data(ser_data), .ser_clk_en(ser_clk_en),
    .ser_frame(ser_frame), .ser_dl(ser_dl)
  );

  always #2 clk = ~clk; // 250 MHz

  int cyc = 0, rx_n = 0, quiet_viol = 0, errs = 0, checks = 0;
  bit done = 0;
  bit mon_b[64], mon_fr[64], mon_dl[64];
  int mon_cyc[64];

  always @(negedge clk) begin
    cyc++;
    if (ser_clk_en && rx_n < 64) begin
      mon_b[rx_n] = ser_data; mon_fr[rx_n] = ser_frame;
      mon_dl[rx_n] = ser_dl; mon_cyc[rx_n] = cyc;
      rx_n++;
    end
    if (in_oof && (ser_clk_en || ser_data || ser_frame || ser_dl)) quiet_viol++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      tick(); cbit_valid = 1'b0; mframe_end = 1'b0; rx_bit = 1'($urandom());
    end
  endtask

  task automatic send_cbits(input logic [20:0] c, input logic [20:0] en, input int maxgap);
    for (int n = 0; n < 21; n++) begin
      idle(maxgap == 0 ? 0 : int'($urandom_range(maxgap, 0)));
      if (en[n]) begin
        tick(); mframe_end = 1'b0; cbit_valid = 1'b1;
        cbit_sub = 3'(n / 3 + 1); cbit_idx = 2'(n % 3 + 1); rx_bit = c[n];
      end
    end
    idle(1);
  endtask

  task automatic end_frame(output int mc);
    tick(); cbit_valid = 1'b0; mframe_end = 1'b1; mc = cyc;
    tick(); mframe_end = 1'b0;
  endtask

  function automatic int cnum(input int k);
    return (k < 5) ? k + 2 : k + 8;
  endfunction

  task automatic check_frame(input logic [20:0] c, input int mc, input int base, input string tag);
    if (rx_n < base + 14) begin
      chk(tag, "pulses", rx_n - base, 14);
      return;
    end
    for (int k = 0; k < 14; k++) begin
      chk(tag, $sformatf("R2 data slot %0d", k), int'(mon_b[base+k]), int'(c[cnum(k)-1]));
      chk("R4", $sformatf("frame slot %0d", k), int'(mon_fr[base+k]), (k == 0) ? 1 : 0);
      chk("R5", $sformatf("dl slot %0d", k), int'(mon_dl[base+k]), (k >= 5 && k <= 7) ? 1 : 0);
      chk("R6", $sformatf("cycle slot %0d", k), mon_cyc[base+k], mc + 1 + k * DIV);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; errs++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [20:0] c, cb, en;
    int mc, mc2, n_a;
    void'($urandom(32'd5521));
    repeat (5) tick();
    rst_n = 1'b1;
    idle(3);
    // R1: reset state
    chk("R1", "ser_clk_en", int'(ser_clk_en), 0);
    chk("R1", "ser_data", int'(ser_data), 0);
    chk("R1", "ser_frame", int'(ser_frame), 0);
    chk("R1", "ser_dl", int'(ser_dl), 0);

    // R8: first boundary after reset carries no frame
    rx_n = 0;
    send_cbits(21'h1FFFFF, 21'h1FFFFF, 1);
    end_frame(mc); idle(14 * DIV + 4);
    chk("R8", "pulses after first boundary", rx_n, 0);

    // R2: random frames
    for (int f = 0; f < 8; f++) begin
      c = 21'($urandom()); rx_n = 0;
      send_cbits(c, 21'h1FFFFF, 2);
      end_frame(mc); idle(14 * DIV + 4);
      chk("R2", "pulse count", rx_n, 14);
      check_frame(c, mc, 0, "R2");
    end

    // R3: unexported C-bits set, exported clear, then the reverse
    rx_n = 0; c = ~EXP_MASK;
    send_cbits(c, 21'h1FFFFF, 1); end_frame(mc); idle(14 * DIV + 4);
    check_frame(c, mc, 0, "R3");
    rx_n = 0; c = EXP_MASK;
    send_cbits(c, 21'h1FFFFF, 1); end_frame(mc); idle(14 * DIV + 4);
    check_frame(c, mc, 0, "R3");

    // R7: only subframes 1..3 offered after an all-ones frame
    rx_n = 0; c = 21'h1FFFFF; en = 21'h0001FF;
    send_cbits(c, en, 1); end_frame(mc); idle(14 * DIV + 4);
    check_frame(c & en, mc, 0, "R7");

    // R8: out-of-frame inside a frame drops it; the following frame is sent
    rx_n = 0; c = 21'($urandom());
    send_cbits(c, 21'h0003FF, 1);
    tick(); in_oof = 1'b1; idle(3); tick(); in_oof = 1'b0;
    send_cbits(c, 21'h1FFC00, 1);
    end_frame(mc); idle(14 * DIV + 4);
    chk("R8", "frame touched by oof", rx_n, 0);
    rx_n = 0; c = 21'($urandom());
    send_cbits(c, 21'h1FFFFF, 1); end_frame(mc); idle(14 * DIV + 4);
    check_frame(c, mc, 0, "R8");

    // R8: out-of-frame during a transmission aborts and silences the port
    rx_n = 0; quiet_viol = 0; c = 21'h1FFFFF;
    send_cbits(c, 21'h1FFFFF, 1); end_frame(mc); idle(2 * DIV);
    tick(); in_oof = 1'b1; idle(5); tick(); in_oof = 1'b0;
    idle(14 * DIV + 4);
    chk("R8", "aborted (pulses < 14)", int'(rx_n < 14), 1);
    chk("R8", "outputs high during oof", quiet_viol, 0);
    rx_n = 0;
    send_cbits(c, 21'h1FFFFF, 1); end_frame(mc); idle(14 * DIV + 4);
    chk("R8", "first frame after oof", rx_n, 0);
    rx_n = 0; c = 21'($urandom());
    send_cbits(c, 21'h1FFFFF, 1); end_frame(mc); idle(14 * DIV + 4);
    check_frame(c, mc, 0, "R8");

    // R9: a frame end during transmission restarts with the new frame
    rx_n = 0; c = 21'($urandom()); cb = ~c;
    send_cbits(c, 21'h1FFFFF, 1); end_frame(mc);
    send_cbits(cb, 21'h1FFFFF, 0); end_frame(mc2);
    idle(14 * DIV + 4);
    n_a = 0;
    for (int k = 0; k < 14; k++) if (mc + 1 + k * DIV <= mc2) n_a++;
    chk("R9", "total pulses", rx_n, n_a + 14);
    check_frame(cb, mc2, n_a, "R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule